// File: doc/BRIEF.md
# Stream Stall Timeout Watchdog

This block watches the stream side of a memory-to-stream DMA read channel and flags a downstream sink that has refused data for too long. The channel is stalled when a transfer still has bytes left to send and the sink is not ready. On the first cycle of a stall the block captures the programmed prescale and timeout values. It then divides the core clock by the prescale value plus one and counts the timeout value down on the divided ticks. When the count runs out it emits a one-cycle stream-timeout pulse, which an interrupt register elsewhere can latch into its status bit 3.

The timer is one-shot: after firing it stays quiet until the stall ends and a new one begins. Whenever the sink accepts data again, or the transfer ends, the timer stops. A later stall is timed afresh from its own first cycle. A separate enable input decides, at the moment of expiry, whether the pulse is actually produced. Out of reset the captured values hold 0xFFF for the prescale and 0xFFE for the timeout.

Top module: `strm_stall_wdog`

## Requirements
- R1: While reset is held and after it is released, `tmo_pulse` is 0 until a stall has been timed out.
- R2: A stall is `xfer_pend`=1 with `sink_rdy`=0. At the first clock edge E0 at which a stall is seen, `pre_div` (P) and `tmo_val` (T) are captured and timing starts.
- R3: With T≥1, the clock edge E0+T·(P+1) ends the stall's timing. `tmo_pulse` is 1 for exactly the one cycle that follows that edge.
- R4: A timeout value of 0 behaves like 1: the pulse follows edge E0+(P+1).
- R5: The pulse is produced only if `tmo_en` is 1 at the expiry edge. Its value at any other edge has no effect.
- R6: After expiry, no further pulse is produced while the same stall continues.
- R7: If the stall clears at any edge before expiry, the timer stops. A new stall is timed from its own E0.
- R8: If the stall clears at the very edge that would expire, no pulse is produced.
- R9: Changes to `pre_div` or `tmo_val` after E0 do not affect the current stall.
- R10: With `xfer_pend`=0, no timing happens, whatever the value of `sink_rdy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tmo_en | input | 1 | Allows the timeout pulse at expiry |
| pre_div | input | 12 | Prescale value; the tick period is pre_div+1 cycles |
| tmo_val | input | 12 | Timeout in prescaled ticks |
| xfer_pend | input | 1 | Transfer has data remaining |
| sink_rdy | input | 1 | Stream sink can accept data |
| tmo_pulse | output | 1 | One-cycle stream-timeout event |

## Verification
Two events can land on the same clock edge: expiry of the count, and an event that cancels it. The canceller is either the sink becoming ready again or the enable being dropped. The bench computes the expiry edge from the captured P and T and changes `sink_rdy` or `tmo_en` in the half cycle just before it. It then judges that no pulse appears at all. In a neighbouring case the enable is dropped only in the middle of the stall, and the pulse must still arrive exactly on time. A scoreboard queue holds the expected pulse cycle for every timed stall, and any pulse that has no entry in the queue fails.

// File: rtl/stall_wd_pkg.sv
package stall_wd_pkg;

   typedef enum logic [1:0] {
      WD_IDLE  = 2'd0,
      WD_RUN   = 2'd1,
      WD_SPENT = 2'd2
   } wd_state_e;

endpackage

// File: rtl/stall_wd_detect.sv
module stall_wd_detect (
   input  logic clk,
   input  logic rst,
   input  logic xfer_pend,
   input  logic sink_rdy,
   output logic stall,
   output logic stall_start
);
   logic stall_q;

   assign stall       = xfer_pend & ~sink_rdy;
   assign stall_start = stall & ~stall_q;

   always_ff @(posedge clk) begin
      if (rst) stall_q <= 1'b0;
      else     stall_q <= stall;
   end

   // R10: no pending transfer means no stall is recorded
   a_r10_no_pend: assert property (@(posedge clk) disable iff (rst)
      !xfer_pend |=> !stall_q);
endmodule

// File: rtl/stall_wd_prescale.sv
module stall_wd_prescale #(
   parameter int                 PRE_W        = 12,
   parameter bit                 USE_PRESCALE = 1'b1,
   parameter logic [PRE_W-1:0]   PRE_RST      = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             run,
   input  logic [PRE_W-1:0] div_val,
   output logic             tick
);
   localparam logic [PRE_W-1:0] PRE_ZERO = '0;

   generate
      if (USE_PRESCALE) begin : g_div
         logic [PRE_W-1:0] pre_cap;
         logic [PRE_W-1:0] pcnt;

         assign tick = run & (pcnt == PRE_ZERO);

         always_ff @(posedge clk) begin
            if (rst) begin
               pre_cap <= PRE_RST;
               pcnt    <= PRE_RST;
            end else if (load) begin
               pre_cap <= div_val;
               pcnt    <= div_val;
            end else if (run) begin
               if (pcnt == PRE_ZERO) pcnt <= pre_cap;
               else                  pcnt <= pcnt - 1'b1;
            end
         end

         // R2: the divider starts from the value present at stall start
         a_r2_load_div: assert property (@(posedge clk) disable iff (rst)
            load |=> (pcnt == $past(div_val)));
         // R9: the running count never exceeds the captured divider
         a_r9_pcnt_bound: assert property (@(posedge clk) disable iff (rst)
            run |-> (pcnt <= pre_cap));
      end else begin : g_nodiv
         assign tick = run;
      end
   endgenerate
endmodule

// File: rtl/stall_wd_count.sv
module stall_wd_count
   import stall_wd_pkg::*;
#(
   parameter int               CNT_W   = 12,
   parameter logic [CNT_W-1:0] CNT_RST = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             stall,
   input  logic             tick,
   input  logic             en,
   input  logic [CNT_W-1:0] tmo_val,
   output logic             fire
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   wd_state_e        st;
   logic [CNT_W-1:0] tcnt;
   logic             last_tick;

   assign last_tick = (tcnt == '0) || (tcnt == CNT_ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= WD_IDLE;
         tcnt <= CNT_RST;
         fire <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (load) begin
            tcnt <= tmo_val;
            st   <= WD_RUN;
         end else if (!stall) begin
            st <= WD_IDLE;
         end else if ((st == WD_RUN) && tick) begin
            if (last_tick) begin
               st   <= WD_SPENT;
               fire <= en;
            end else begin
               tcnt <= tcnt - 1'b1;
            end
         end
      end
   end

   // R6: a spent timer stays silent for the rest of the stall
   a_r6_one_shot: assert property (@(posedge clk) disable iff (rst)
      (st == WD_SPENT) && stall && !load |=> (st == WD_SPENT) && !fire);
   // R7: the timer leaves the running state when the stall clears
   a_r7_stop: assert property (@(posedge clk) disable iff (rst)
      !stall |=> (st == WD_IDLE));
endmodule

// File: rtl/strm_stall_wdog.sv
module strm_stall_wdog #(
   parameter int                 PRE_W        = 12,
   parameter int                 CNT_W        = 12,
   parameter bit                 USE_PRESCALE = 1'b1,
   parameter logic [PRE_W-1:0]   PRE_RST      = PRE_W'(12'hFFF),
   parameter logic [CNT_W-1:0]   CNT_RST      = CNT_W'(12'hFFE)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tmo_en,
   input  logic [PRE_W-1:0] pre_div,
   input  logic [CNT_W-1:0] tmo_val,
   input  logic             xfer_pend,
   input  logic             sink_rdy,
   output logic             tmo_pulse
);
   generate
      if (PRE_W < 1 || PRE_W > 32) begin : g_bad_pre
         $error("strm_stall_wdog: PRE_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("strm_stall_wdog: CNT_W out of range");
      end
   endgenerate

   logic stall;
   logic stall_start;
   logic tick;

   stall_wd_detect u_det (
      .clk         (clk),
      .rst         (rst),
      .xfer_pend   (xfer_pend),
      .sink_rdy    (sink_rdy),
      .stall       (stall),
      .stall_start (stall_start)
   );

   stall_wd_prescale #(
      .PRE_W        (PRE_W),
      .USE_PRESCALE (USE_PRESCALE),
      .PRE_RST      (PRE_RST)
   ) u_pre (
      .clk     (clk),
      .rst     (rst),
      .load    (stall_start),
      .run     (stall & ~stall_start),
      .div_val (pre_div),
      .tick    (tick)
   );

   stall_wd_count #(
      .CNT_W   (CNT_W),
      .CNT_RST (CNT_RST)
   ) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .load    (stall_start),
      .stall   (stall),
      .tick    (tick),
      .en      (tmo_en),
      .tmo_val (tmo_val),
      .fire    (tmo_pulse)
   );

   // R3: the event lasts one cycle
   a_r3_single_cycle: assert property (@(posedge clk) disable iff (rst)
      tmo_pulse |=> !tmo_pulse);
   // R5: a pulse needs the enable at the expiry edge
   a_r5_gated: assert property (@(posedge clk) disable iff (rst)
      tmo_pulse |-> $past(tmo_en));
   // R8: a pulse needs the stall to still hold at the expiry edge
   a_r8_resume_wins: assert property (@(posedge clk) disable iff (rst)
      tmo_pulse |-> $past(stall));
   // R1: nothing fires in the cycle after reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      $past(rst) |-> !tmo_pulse);
endmodule

// File: tb/sim_strm_stall_wdog.sv
module sim_strm_stall_wdog;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        tmo_en = 1'b1;
   logic [11:0] pre_div = '0;
   logic [11:0] tmo_val = '0;
   logic        xfer_pend = 1'b0;
   logic        sink_rdy = 1'b1;
   logic        tmo_pulse;

   int cyc = 0;
   int total = 0;
   int bad = 0;
   int npulse = 0;
   int exp_q[$];
   bit done = 1'b0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   strm_stall_wdog u0 (
      .clk(clk), .rst(rst), .tmo_en(tmo_en), .pre_div(pre_div),
      .tmo_val(tmo_val), .xfer_pend(xfer_pend), .sink_rdy(sink_rdy),
      .tmo_pulse(tmo_pulse)
   );

   // monitor: every pulse must match the head of the expectation queue
   always @(negedge clk) begin
      if (!rst && tmo_pulse) begin
         npulse++;
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R3/R5/R6/R8: unexpected pulse at cycle %0d, expected none", cyc);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != cyc) begin
               bad++;
               $display("FAIL R3: pulse at cycle %0d, expected %0d", cyc, e);
            end
         end
      end
   end

   task automatic check(input string req, input int act, input int expv);
      total++;
      if (act != expv) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // driver: begin a stall now (called at a negedge) and queue its expiry
   task automatic stall_go(input int p, input int t, input bit expect_it);
      int ticks;
      pre_div   = 12'(p);
      tmo_val   = 12'(t);
      xfer_pend = 1'b1;
      sink_rdy  = 1'b0;
      ticks = (t == 0) ? 1 : t;
      if (expect_it) exp_q.push_back(cyc + 1 + ticks * (p + 1));
   endtask

   task automatic go_idle();
      xfer_pend = 1'b0;
      sink_rdy  = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not end, actual hung expected finish");
      finish_run();
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      check("R1 reset", int'(tmo_pulse), 0);
      rst = 1'b0;
      wait_n(4);
      check("R1 idle after reset", npulse, 0);

      // R3 basic: P=2, T=3; R6 stays silent afterwards
      stall_go(2, 3, 1'b1);
      wait_n(12);
      base = npulse;
      wait_n(30);
      check("R6 no second pulse", npulse, base);
      go_idle();

      // R3 no division
      stall_go(0, 5, 1'b1);
      wait_n(10);
      go_idle();

      // R4 zero timeout behaves as one
      stall_go(3, 0, 1'b1);
      wait_n(8);
      go_idle();

      // R5 enable low throughout
      tmo_en = 1'b0;
      base = npulse;
      stall_go(1, 2, 1'b0);
      wait_n(20);
      check("R5 disabled no pulse", npulse, base);
      go_idle();
      tmo_en = 1'b1;

      // R5 enable dropped mid stall but high at expiry
      stall_go(1, 6, 1'b1);
      wait_n(3);
      tmo_en = 1'b0;
      wait_n(2);
      tmo_en = 1'b1;
      wait_n(12);
      go_idle();

      // R5 enable dropped exactly at expiry edge
      base = npulse;
      stall_go(2, 2, 1'b0);
      wait_n(2 * 3);
      tmo_en = 1'b0;
      wait_n(1);
      tmo_en = 1'b1;
      wait_n(10);
      check("R5 enable low at expiry", npulse, base);
      go_idle();

      // R7 interrupted stall, retimed from restart
      base = npulse;
      stall_go(1, 5, 1'b0);
      wait_n(6);
      sink_rdy = 1'b1;
      wait_n(1);
      check("R7 no pulse from interrupted stall", npulse, base);
      stall_go(1, 5, 1'b1);
      wait_n(14);
      go_idle();

      // R8 sink resumes at the expiry edge
      base = npulse;
      stall_go(3, 2, 1'b0);
      wait_n(2 * 4);
      sink_rdy = 1'b1;
      wait_n(12);
      check("R8 resume wins over expiry", npulse, base);
      go_idle();

      // R7 recurrence right after firing gives a second pulse
      stall_go(0, 3, 1'b1);
      wait_n(5);
      sink_rdy = 1'b1;
      wait_n(1);
      stall_go(0, 3, 1'b1);
      wait_n(6);
      go_idle();

      // R9 value changes after stall start are ignored
      stall_go(1, 4, 1'b1);
      wait_n(2);
      pre_div = 12'd7;
      tmo_val = 12'd50;
      wait_n(12);
      go_idle();

      // R10 no pending transfer, sink busy
      base = npulse;
      pre_div   = 12'd0;
      tmo_val   = 12'd1;
      xfer_pend = 1'b0;
      sink_rdy  = 1'b0;
      wait_n(20);
      check("R10 no timing without pending transfer", npulse, base);
      go_idle();

      wait_n(5);
      check("R3 all expected pulses seen", exp_q.size(), 0);
      finish_run();
   end
endmodule